// File: doc/BRIEF.md
# Machine-Tagged Dual-Array Translation Lookup

This block turns a virtual address into a physical address for a core that runs its own native code and a foreign guest side by side. It holds two entry arrays. The host array is small and fully associative, and each of its entries has its own page mask. The guest array is larger, and all of its entries share one page size that is fixed by a parameter, 4 KB by default. Every entry carries a 2-bit machine tag. The machine tag of a request decides which array is searched, and it must also equal the entry's tag for the entry to match. Host and guest address spaces therefore never answer each other's requests.

Each entry maps a pair of pages, an even one and an odd one. The address bit just above the page offset chooses between them. Each page has its own frame number, a valid flag and a writable flag. A request presents a machine tag, an ASID, a virtual address and a load/store flag. The result is registered and appears one cycle after the request strobe. It is either a hit with a physical address, or a miss, invalid or modify exception code. Entries are loaded through a simple write port that is driven from outside the block.

Top module: `mtlb_lookup`

## Requirements
- R1: After reset no entry is live: `rsp_valid` is 0, `rsp_exc` is 00 and `rsp_pa` is 0, and every lookup made before any write returns the miss code.
- R2: A response appears on `rsp_valid`/`rsp_hit`/`rsp_exc`/`rsp_pa` in the cycle after `req` is high. In a cycle after `req` is low, `rsp_valid` is 0 and the other response outputs hold their values.
- R3: Requests with tag 0 or 1 search only the host array (`wr_guest`=0). Requests with tag 2 or 3 search only the guest array (`wr_guest`=1). An entry matches only if its stored tag equals the request tag.
- R4: An entry matches only if its ASID equals the request ASID.
- R5: A host entry compares the VPN2 field (address bits 31:13) with each set bit i of its own `wr_pmask` ignoring address bit 13+i. A value of 3 gives 16 KB pages and 0 gives 4 KB pages. Guest entries all use the 4 KB page size from the global mask parameter.
- R6: With n set bits in the effective mask, address bit 12+n selects the odd page (1) or the even page (0). On a hit, `rsp_pa` is the selected frame number shifted left by 12, with its low 12+n bits replaced by the address's low 12+n bits.
- R7: Exception codes are 00 none, 01 miss, 10 invalid, 11 modify. `rsp_hit` is 1 exactly when the code is 00. When there is no match the code is 01 and `rsp_pa` is 0.
- R8: If an entry matches but the selected page's valid flag is 0, the code is 10.
- R9: A store (`req_store`=1) to a valid page whose writable flag is 0 gives code 11. A load to the same page hits.
- R10: If several entries in the searched array match, the one with the lowest index supplies the result.
- R11: A write to an index that is already occupied replaces the whole entry. From the next cycle on, lookups see only the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_guest | input | 1 | Write target: 0 host array, 1 guest array |
| wr_idx | input | WI_W | Entry index within the target array |
| wr_mid | input | 2 | Machine tag of the written entry |
| wr_asid | input | 8 | ASID of the written entry |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31:13) |
| wr_pmask | input | 8 | Per-entry page mask (host array only) |
| wr_pfn_e | input | 20 | Even page frame number |
| wr_v_e | input | 1 | Even page valid |
| wr_d_e | input | 1 | Even page writable |
| wr_pfn_o | input | 20 | Odd page frame number |
| wr_v_o | input | 1 | Odd page valid |
| wr_d_o | input | 1 | Odd page writable |
| req | input | 1 | Lookup strobe |
| req_mid | input | 2 | Machine tag of the lookup |
| req_asid | input | 8 | ASID of the lookup |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response strobe, one cycle after req |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_exc | output | 2 | Exception code |
| rsp_pa | output | 32 | Physical address (0 unless hit) |

## Verification
The arrays are filled with entries that share a page pair but differ only in machine tag, only in ASID, or only in index. A sweep then crosses all four tags, three ASIDs, loads and stores, and addresses near the page and pair boundaries of both page sizes. Every result is compared against an arithmetic model that works with division and remainder. These patterns separate wrong routing, missing tag or ASID compares, wrong mask handling, a wrong even/odd bit and the wrong priority. Hand-worked cases pin down each exception code, the behaviour on reset and overwrite, and the one-cycle timing with its hold.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFS_W  = 12;
  parameter int PFN_W  = VA_W - OFS_W;
  parameter int VPN2_W = VA_W - OFS_W - 1;
  parameter int ASID_W = 8;
  parameter int MASK_W = 8;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'b00,
    EXC_MISS  = 2'b01,
    EXC_INVAL = 2'b10,
    EXC_MOD   = 2'b11
  } exc_t;

  typedef struct packed {
    logic [MASK_W-1:0] pmask;
    logic [PFN_W-1:0]  pfn_e;
    logic              v_e;
    logic              d_e;
    logic [PFN_W-1:0]  pfn_o;
    logic              v_o;
    logic              d_o;
  } xlat_t;

  typedef struct packed {
    logic [1:0]        mid;
    logic [ASID_W-1:0] asid;
    logic [VPN2_W-1:0] vpn2;
    xlat_t             xl;
  } tlb_ent_t;
endpackage

// File: rtl/mtlb_prio.sv
module mtlb_prio #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    found = |vec;
    sel   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) sel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/mtlb_bank.sv
module mtlb_bank
  import mtlb_pkg::*;
#(
  parameter int              N              = 4,
  parameter int              WI_W           = 3,
  parameter bit              PER_ENTRY_MASK = 1'b1,
  parameter logic [MASK_W-1:0] GLOBAL_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WI_W-1:0]   wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [1:0]        lk_mid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN2_W-1:0] lk_vpn2,
  output logic              found,
  output xlat_t             sel_xl
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      live_q;
  logic [N-1:0]      we;
  logic [N-1:0]      hitv;
  tlb_ent_t          pay_q [N];
  logic [MASK_W-1:0] emask [N];
  logic [SEL_W-1:0]  sel_idx;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign we[i] = wr_en && (wr_idx == WI_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     live_q[i] <= 1'b0;
      else if (we[i]) live_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we[i]) pay_q[i] <= wr_ent;
    end

    if (PER_ENTRY_MASK) begin : g_own
      assign emask[i] = pay_q[i].xl.pmask;
    end else begin : g_glob
      assign emask[i] = GLOBAL_MASK | (pay_q[i].xl.pmask & '0);
    end

    assign hitv[i] = live_q[i]
                  && (pay_q[i].mid == lk_mid)
                  && (pay_q[i].asid == lk_asid)
                  && (((pay_q[i].vpn2 ^ lk_vpn2)
                       & ~{{(VPN2_W-MASK_W){1'b0}}, emask[i]}) == '0);
  end

  mtlb_prio #(.N(N), .SEL_W(SEL_W)) u_prio (
    .vec   (hitv),
    .found (found),
    .sel   (sel_idx)
  );

  always_comb begin
    sel_xl       = pay_q[sel_idx].xl;
    sel_xl.pmask = emask[sel_idx];
  end
endmodule

// File: rtl/mtlb_resolve.sv
module mtlb_resolve
  import mtlb_pkg::*;
(
  input  logic            found,
  input  xlat_t           xl,
  input  logic [VA_W-1:0] va,
  input  logic            store,
  output logic            hit,
  output exc_t            exc,
  output logic [VA_W-1:0] pa
);
  int              n_ones;
  logic            odd;
  logic [VA_W-1:0] offm;
  logic [PFN_W-1:0] pfn;
  logic            pg_v;
  logic            pg_d;

  always_comb begin
    n_ones = $countones(xl.pmask);
    odd    = va[OFS_W + n_ones];
    for (int k = 0; k < VA_W; k++) begin
      if (k < OFS_W)                offm[k] = 1'b1;
      else if (k < OFS_W + MASK_W)  offm[k] = xl.pmask[k - OFS_W];
      else                          offm[k] = 1'b0;
    end
    pfn  = odd ? xl.pfn_o : xl.pfn_e;
    pg_v = odd ? xl.v_o   : xl.v_e;
    pg_d = odd ? xl.d_o   : xl.d_e;

    if (!found)            exc = EXC_MISS;
    else if (!pg_v)        exc = EXC_INVAL;
    else if (store && !pg_d) exc = EXC_MOD;
    else                   exc = EXC_NONE;

    hit = found && pg_v && (!store || pg_d);
    pa  = hit ? (({pfn, {OFS_W{1'b0}}} & ~offm) | (va & offm)) : '0;
  end
endmodule

// File: rtl/mtlb_lookup.sv
module mtlb_lookup
  import mtlb_pkg::*;
#(
  parameter int                HOST_N     = 4,
  parameter int                GUEST_N    = 8,
  parameter logic [MASK_W-1:0] GUEST_MASK = '0,
  localparam int               MAX_N      = (HOST_N > GUEST_N) ? HOST_N : GUEST_N,
  localparam int               WI_W       = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_guest,
  input  logic [WI_W-1:0]   wr_idx,
  input  logic [1:0]        wr_mid,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [MASK_W-1:0] wr_pmask,
  input  logic [PFN_W-1:0]  wr_pfn_e,
  input  logic              wr_v_e,
  input  logic              wr_d_e,
  input  logic [PFN_W-1:0]  wr_pfn_o,
  input  logic              wr_v_o,
  input  logic              wr_d_o,
  input  logic              req,
  input  logic [1:0]        req_mid,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_store,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_exc,
  output logic [VA_W-1:0]   rsp_pa
);
  tlb_ent_t        wr_ent;
  logic            h_found, g_found, sel_found;
  xlat_t           h_xl, g_xl, sel_xl;
  logic            guest_path;
  logic            c_hit;
  exc_t            c_exc;
  logic [VA_W-1:0] c_pa;

  logic            valid_d, hit_d;
  logic [1:0]      exc_d;
  logic [VA_W-1:0] pa_d;

  always_comb begin
    wr_ent.mid      = wr_mid;
    wr_ent.asid     = wr_asid;
    wr_ent.vpn2     = wr_vpn2;
    wr_ent.xl.pmask = wr_pmask;
    wr_ent.xl.pfn_e = wr_pfn_e;
    wr_ent.xl.v_e   = wr_v_e;
    wr_ent.xl.d_e   = wr_d_e;
    wr_ent.xl.pfn_o = wr_pfn_o;
    wr_ent.xl.v_o   = wr_v_o;
    wr_ent.xl.d_o   = wr_d_o;
  end

  mtlb_bank #(
    .N(HOST_N), .WI_W(WI_W), .PER_ENTRY_MASK(1'b1), .GLOBAL_MASK('0)
  ) u_host (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_guest), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .lk_mid(req_mid), .lk_asid(req_asid),
    .lk_vpn2(req_va[VA_W-1:OFS_W+1]),
    .found(h_found), .sel_xl(h_xl)
  );

  mtlb_bank #(
    .N(GUEST_N), .WI_W(WI_W), .PER_ENTRY_MASK(1'b0), .GLOBAL_MASK(GUEST_MASK)
  ) u_guest (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_guest), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .lk_mid(req_mid), .lk_asid(req_asid),
    .lk_vpn2(req_va[VA_W-1:OFS_W+1]),
    .found(g_found), .sel_xl(g_xl)
  );

  assign guest_path = req_mid[1];
  assign sel_found  = guest_path ? g_found : h_found;
  assign sel_xl     = guest_path ? g_xl    : h_xl;

  mtlb_resolve u_res (
    .found(sel_found), .xl(sel_xl), .va(req_va), .store(req_store),
    .hit(c_hit), .exc(c_exc), .pa(c_pa)
  );

  always_comb begin
    valid_d = req;
    hit_d   = rsp_hit;
    exc_d   = rsp_exc;
    pa_d    = rsp_pa;
    if (req) begin
      hit_d = c_hit;
      exc_d = c_exc;
      pa_d  = c_pa;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_exc   <= EXC_NONE;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_exc   <= exc_d;
      rsp_pa    <= pa_d;
    end
  end
endmodule

// File: rtl/mtlb_lookup_chk.sv
module mtlb_lookup_chk
  import mtlb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            req_store,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [1:0]      rsp_exc,
  input logic [VA_W-1:0] rsp_pa
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rsp_valid && rsp_pa == '0 && rsp_exc == 2'b00)
        else $error("reset state wrong");
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!rsp_valid && $stable(rsp_pa) && $stable(rsp_exc) && $stable(rsp_hit)));

  p_hit_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_exc == 2'b00)));

  p_miss_pa_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));

  p_load_no_modify_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_store) |=> (rsp_exc != 2'b11));
endmodule

bind mtlb_lookup mtlb_lookup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_store(req_store),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_exc(rsp_exc), .rsp_pa(rsp_pa)
);

// File: tb/mtlb_lookup_test.sv
module mtlb_lookup_test;
  localparam int HN = 4;
  localparam int GN = 8;
  localparam int WI = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_guest, wr_v_e, wr_d_e, wr_v_o, wr_d_o;
  logic [WI-1:0] wr_idx;
  logic [1:0]  wr_mid;
  logic [7:0]  wr_asid;
  logic [18:0] wr_vpn2;
  logic [7:0]  wr_pmask;
  logic [19:0] wr_pfn_e, wr_pfn_o;
  logic        req, req_store;
  logic [1:0]  req_mid;
  logic [7:0]  req_asid;
  logic [31:0] req_va;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_exc;
  logic [31:0] rsp_pa;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side copy of what was written, indexed [array][idx], array 0 host, 1 guest
  bit          m_live [2][8];
  logic [1:0]  m_mid  [2][8];
  logic [7:0]  m_asid [2][8];
  logic [31:0] m_base [2][8];
  int          m_n    [2][8];
  logic [19:0] m_pfe  [2][8];
  logic [19:0] m_pfo  [2][8];
  bit          m_ve [2][8], m_de [2][8], m_vo [2][8], m_do [2][8];

  always #5 clk = ~clk;

  mtlb_lookup uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_guest(wr_guest), .wr_idx(wr_idx),
    .wr_mid(wr_mid), .wr_asid(wr_asid), .wr_vpn2(wr_vpn2), .wr_pmask(wr_pmask),
    .wr_pfn_e(wr_pfn_e), .wr_v_e(wr_v_e), .wr_d_e(wr_d_e),
    .wr_pfn_o(wr_pfn_o), .wr_v_o(wr_v_o), .wr_d_o(wr_d_o),
    .req(req), .req_mid(req_mid), .req_asid(req_asid), .req_va(req_va),
    .req_store(req_store), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_exc(rsp_exc), .rsp_pa(rsp_pa)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input bit g, input int idx, input logic [1:0] mid, input logic [7:0] asid,
                     input logic [31:0] base, input int n,
                     input logic [19:0] pfe, input bit ve, input bit de,
                     input logic [19:0] pfo, input bit vo, input bit dd);
    @(negedge clk);
    wr_en = 1'b1; wr_guest = g; wr_idx = WI'(idx); wr_mid = mid; wr_asid = asid;
    wr_vpn2 = base[31:13]; wr_pmask = 8'((1 << n) - 1);
    wr_pfn_e = pfe; wr_v_e = ve; wr_d_e = de; wr_pfn_o = pfo; wr_v_o = vo; wr_d_o = dd;
    @(negedge clk);
    wr_en = 1'b0;
    m_live[g][idx] = 1'b1; m_mid[g][idx] = mid; m_asid[g][idx] = asid;
    m_base[g][idx] = base; m_n[g][idx] = g ? 0 : n;
    m_pfe[g][idx] = pfe; m_ve[g][idx] = ve; m_de[g][idx] = de;
    m_pfo[g][idx] = pfo; m_vo[g][idx] = vo; m_do[g][idx] = dd;
  endtask

  task automatic look(input logic [1:0] mid, input logic [7:0] asid,
                      input logic [31:0] va, input bit st);
    @(negedge clk);
    req = 1'b1; req_mid = mid; req_asid = asid; req_va = va; req_store = st;
    @(negedge clk);
    req = 1'b0;
  endtask

  // arithmetic model from the requirements
  task automatic model(input logic [1:0] mid, input logic [7:0] asid, input logic [31:0] va,
                       input bit st, output logic [1:0] exc, output logic [31:0] pa);
    int g = mid[1] ? 1 : 0;
    int lim = g ? GN : HN;
    bit found = 1'b0;
    exc = 2'b01; pa = 32'h0;
    for (int i = 0; i < lim; i++) begin
      if (!found && m_live[g][i] && m_mid[g][i] == mid && m_asid[g][i] == asid) begin
        longint ps = longint'(4096) << m_n[g][i];
        if ((longint'(va) / (2 * ps)) == (longint'(m_base[g][i]) / (2 * ps))) begin
          bit odd = ((longint'(va) / ps) % 2) == 1;
          logic [19:0] pf = odd ? m_pfo[g][i] : m_pfe[g][i];
          bit v = odd ? m_vo[g][i] : m_ve[g][i];
          bit d = odd ? m_do[g][i] : m_de[g][i];
          found = 1'b1;
          if (!v)           exc = 2'b10;
          else if (st && !d) exc = 2'b11;
          else begin
            exc = 2'b00;
            pa = 32'(longint'(pf) * 4096 + (longint'(va) % ps));
          end
        end
      end
    end
  endtask

  task automatic expect_look(input string tag, input logic [1:0] mid, input logic [7:0] asid,
                             input logic [31:0] va, input bit st,
                             input logic [1:0] e_exc, input logic [31:0] e_pa);
    look(mid, asid, va, st);
    chk({tag, " code"}, 32'(rsp_exc), 32'(e_exc));
    chk({tag, " pa"}, rsp_pa, e_pa);
    chk({tag, " hit"}, 32'(rsp_hit), 32'(e_exc == 2'b00));
  endtask

  task automatic sweep(input string tag);
    logic [31:0] bases [4] = '{32'h0040_0000, 32'h0080_0000, 32'h1000_0000, 32'h0000_0000};
    logic [31:0] offs [9] = '{32'h0, 32'h0FFC, 32'h1000, 32'h1FF8, 32'h2000,
                              32'h3004, 32'h4000, 32'h6FFC, 32'h8000};
    logic [7:0]  asids [3] = '{8'd5, 8'd7, 8'd9};
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 9; o++)
        for (int m = 0; m < 4; m++)
          for (int a = 0; a < 3; a++)
            for (int s = 0; s < 2; s++) begin
              logic [1:0]  e_exc;
              logic [31:0] e_pa;
              logic [31:0] va = bases[b] + offs[o];
              model(2'(m), asids[a], va, s[0], e_exc, e_pa);
              look(2'(m), asids[a], va, s[0]);
              chk({tag, " code"}, 32'(rsp_exc), 32'(e_exc));
              chk({tag, " pa"}, rsp_pa, e_pa);
            end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_guest = 1'b0; wr_idx = '0; wr_mid = '0; wr_asid = '0;
    wr_vpn2 = '0; wr_pmask = '0; wr_pfn_e = '0; wr_v_e = 0; wr_d_e = 0;
    wr_pfn_o = '0; wr_v_o = 0; wr_d_o = 0;
    req = 1'b0; req_mid = '0; req_asid = '0; req_va = '0; req_store = 1'b0;
    for (int g = 0; g < 2; g++) for (int i = 0; i < 8; i++) m_live[g][i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", 32'(rsp_valid), 0);
    chk("R1 code at reset", 32'(rsp_exc), 0);
    chk("R1 pa at reset", rsp_pa, 0);
    rst_n = 1'b1;
    expect_look("R1 empty host", 2'd0, 8'd5, 32'h0040_0000, 1'b0, 2'b01, 32'h0);
    expect_look("R1 empty guest", 2'd3, 8'd5, 32'h0040_0000, 1'b0, 2'b01, 32'h0);

    put(0, 0, 2'd0, 8'd5, 32'h0040_0000, 2, 20'h00100, 1, 1, 20'h00104, 1, 0);
    put(0, 1, 2'd1, 8'd5, 32'h0040_0000, 2, 20'h00200, 1, 1, 20'h00204, 0, 0);
    put(0, 2, 2'd0, 8'd7, 32'h0080_0000, 0, 20'h00300, 0, 0, 20'h00301, 1, 1);
    put(0, 3, 2'd0, 8'd5, 32'h0040_0000, 2, 20'h00F00, 1, 1, 20'h00F04, 1, 1);
    put(1, 0, 2'd2, 8'd5, 32'h0040_0000, 0, 20'h01000, 1, 1, 20'h01001, 1, 1);
    put(1, 1, 2'd3, 8'd5, 32'h0040_0000, 0, 20'h02000, 1, 0, 20'h02001, 0, 0);
    put(1, 2, 2'd3, 8'd9, 32'h1000_0000, 0, 20'h03000, 1, 1, 20'h03001, 1, 0);
    put(1, 3, 2'd0, 8'd5, 32'h0040_0000, 0, 20'h04000, 1, 1, 20'h04001, 1, 1);
    put(1, 4, 2'd2, 8'd5, 32'h0040_0000, 0, 20'h05000, 1, 1, 20'h05001, 1, 1);
    put(1, 5, 2'd2, 8'd7, 32'h0080_0000, 0, 20'h06000, 1, 1, 20'h06001, 1, 1);

    // R6: 16 KB host page pair, odd select on bit 14
    expect_look("R6 even 16K", 2'd0, 8'd5, 32'h0040_2345, 1'b0, 2'b00, 32'h0010_2345);
    expect_look("R6 odd 16K", 2'd0, 8'd5, 32'h0040_6010, 1'b0, 2'b00, 32'h0010_6010);
    // R9
    expect_look("R9 store ro", 2'd0, 8'd5, 32'h0040_6010, 1'b1, 2'b11, 32'h0);
    expect_look("R9 store rw", 2'd0, 8'd5, 32'h0040_0010, 1'b1, 2'b00, 32'h0010_0010);
    expect_look("R9 guest store ro", 2'd3, 8'd5, 32'h0040_0008, 1'b1, 2'b11, 32'h0);
    // R8
    expect_look("R8 host odd invalid", 2'd1, 8'd5, 32'h0040_4000, 1'b0, 2'b10, 32'h0);
    expect_look("R8 4K even invalid", 2'd0, 8'd7, 32'h0080_0000, 1'b0, 2'b10, 32'h0);
    expect_look("R8 4K odd ok", 2'd0, 8'd7, 32'h0080_1004, 1'b0, 2'b00, 32'h0030_1004);
    expect_look("R8 guest odd invalid", 2'd3, 8'd5, 32'h0040_1008, 1'b0, 2'b10, 32'h0);
    // R3
    expect_look("R3 guest tag2", 2'd2, 8'd5, 32'h0040_0004, 1'b0, 2'b00, 32'h0100_0004);
    expect_look("R3 host tag1", 2'd1, 8'd5, 32'h0040_0000, 1'b0, 2'b00, 32'h0020_0000);
    expect_look("R3 host tag0", 2'd0, 8'd5, 32'h0040_0004, 1'b0, 2'b00, 32'h0010_0004);
    expect_look("R3 guest tag3 other asid", 2'd3, 8'd9, 32'h1000_1000, 1'b0, 2'b00, 32'h0300_1000);
    // R4
    expect_look("R4 asid mismatch", 2'd2, 8'd9, 32'h0040_0000, 1'b0, 2'b01, 32'h0);
    // R5
    expect_look("R5 guest 4K beyond pair", 2'd2, 8'd5, 32'h0040_2000, 1'b0, 2'b01, 32'h0);
    expect_look("R5 host 16K top", 2'd0, 8'd5, 32'h0040_7FFC, 1'b0, 2'b00, 32'h0010_7FFC);
    expect_look("R5 host 16K beyond pair", 2'd0, 8'd5, 32'h0040_8000, 1'b0, 2'b01, 32'h0);
    // R7
    expect_look("R7 miss", 2'd0, 8'd9, 32'h1234_5678, 1'b0, 2'b01, 32'h0);
    // R10
    expect_look("R10 guest lowest wins", 2'd2, 8'd5, 32'h0040_1000, 1'b0, 2'b00, 32'h0100_1000);

    // R2: one-cycle response then hold while idle
    @(negedge clk);
    req = 1'b1; req_mid = 2'd0; req_asid = 8'd5; req_va = 32'h0040_0100; req_store = 1'b0;
    chk("R2 not before edge", 32'(rsp_valid), 0);
    @(negedge clk);
    req = 1'b0; req_va = 32'h0000_0000;
    chk("R2 valid next cycle", 32'(rsp_valid), 1);
    chk("R2 pa next cycle", rsp_pa, 32'h0010_0100);
    repeat (3) @(negedge clk);
    chk("R2 idle valid low", 32'(rsp_valid), 0);
    chk("R2 idle pa held", rsp_pa, 32'h0010_0100);
    chk("R2 idle code held", 32'(rsp_exc), 0);

    sweep("R3 R4 R5 R6 R10 sweep");

    // R11: overwrite host entry 0
    put(0, 0, 2'd0, 8'd5, 32'h0040_0000, 2, 20'h00400, 1, 1, 20'h00404, 1, 1);
    expect_look("R11 overwrite even", 2'd0, 8'd5, 32'h0040_0010, 1'b0, 2'b00, 32'h0040_0010);
    expect_look("R11 overwrite store now ok", 2'd0, 8'd5, 32'h0040_6010, 1'b1, 2'b00, 32'h0040_6010);
    sweep("R11 sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule